// File: doc/BRIEF.md
# Dynamic Cache Way Sizing Controller

This block sets how many ways of a second-level cache, shared by two cores, stay enabled while the package moves in and out of its deepest idle state. The package can enter deep sleep only when certain conditions hold. Both cores must request C4, the deep-sleep enable must be set, the stop-clock request must be active, and the hold-full flag must be clear. On each such entry the block may shrink the cache by a programmable step. It flushes each way it gives up through a one-way-at-a-time request/acknowledge handshake. It grants deep sleep only after the last flush has been acknowledged.

Two conditions block shrinking. One is a bus-to-core speed ratio that is not below a programmable threshold. The other is a residency timer that has expired; this timer counts cycles spent in the normal running state. A ratio of zero is ignored. When the deep-sleep conditions go away, the cache grows back to at least two ways. Later, an interrupt can restore the whole cache if the ratio is high, if the timer has expired, or if the core not servicing the interrupt is in a light idle state. Every way that becomes enabled again is marked for invalidation in the cycle it is re-enabled.

Top module: `dcs_way_ctrl`

## Requirements
- R1: After reset, ways_en_o equals NUM_WAYS, flush_req_o and inv_req_o are zero, and deep_ok_o and grow_req_o are low.
- R2: Deep-sleep entry is taken when both core C-state inputs equal 4, deep_en_i and stop_clk_i are high, and hold_full_i is low. Entry never happens while deep_en_i is low. If shrinking is allowed, the enabled count falls by step_i. The disabled ways are flushed highest index first: flush_req_o is one-hot at bit (ways_en_o-1) and held until flush_ack_i, and each acknowledged cycle lowers ways_en_o by one.
- R3: deep_ok_o is high only in the deep-sleep state, which is reached after the last flush acknowledge. It is never high while a flush request is pending.
- R4: The ratio counts as low when ratio_i is 0 or ratio_i < thr_i, and as high when ratio_i is nonzero and ratio_i > thr_i. grow_req_o reflects the high case in the same cycle. An entry while the ratio is not low skips shrinking and grants deep sleep one cycle later.
- R5: The residency timer counts cycles in the running state. After timeout_i such cycles without an entry, it sets a sticky expired flag. An entry taken while the flag is set does not shrink. Every entry clears the counter and the flag.
- R6: When the deep-sleep conditions drop while deep sleep is granted, the block returns to running. If fewer than 2 ways were enabled, ways_en_o becomes 2 and inv_req_o pulses for one cycle with the bits of the re-enabled ways.
- R7: The first entry after a wake that raised the count to 2 shrinks to zero ways, whatever step_i is.
- R8: In the running state, an irq_i pulse restores ways_en_o to NUM_WAYS on the next cycle if any of these holds: the ratio is high, the timer has expired, or the core not named by irq_core_i (0 or 1) is in C-state 1, 2 or 3. inv_req_o flags the re-enabled ways. Otherwise the interrupt has no effect.
- R9: While hold_full_i is high, deep_ok_o is low and no entry is taken. From the running state, the count returns to NUM_WAYS, with inv_req_o flagging the re-enabled ways.
- R10: The shrink saturates. A step_i larger than the enabled count leaves zero ways. A step_i of zero grants deep sleep without any flush.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| core0_cst_i | input | 3 | C-state requested by core 0 (0..4) |
| core1_cst_i | input | 3 | C-state requested by core 1 (0..4) |
| deep_en_i | input | 1 | Enhanced deep-sleep enable |
| stop_clk_i | input | 1 | Stop-clock request |
| irq_i | input | 1 | Interrupt event pulse |
| irq_core_i | input | 1 | Core servicing the interrupt |
| ratio_i | input | RATIO_W | Bus-to-core speed ratio, 0 = ignore |
| thr_i | input | RATIO_W | Shrink threshold |
| step_i | input | WAY_W | Ways removed per entry |
| timeout_i | input | TIMER_W | Residency timeout in cycles |
| hold_full_i | input | 1 | Shrink prevention |
| flush_ack_i | input | 1 | Flush acknowledge |
| ways_en_o | output | WAY_W | Enabled way count |
| flush_req_o | output | NUM_WAYS | One-hot flush request |
| inv_req_o | output | NUM_WAYS | One-cycle invalidate mask |
| grow_req_o | output | 1 | Expansion request (ratio high) |
| deep_ok_o | output | 1 | Deep-sleep permit |

## Verification
A wrong shrink target or a lost woke flag shows at the ports within one cycle of the entry. It appears as the wrong first flush bit or as a flush sequence of the wrong length. A bad expired flag or ratio decision shows up as a flush where a direct grant was due, or the reverse. It can also show as an interrupt that fails to restore the full count on the next cycle. A corrupted way count is caught at the next wake or interrupt through the invalidate mask. That mask must equal exactly the range of ways being re-enabled.

// File: rtl/dcs_pkg.sv
package dcs_pkg;
  typedef enum logic [1:0] {ST_RUN, ST_FLUSH, ST_SLEEP} dcs_state_e;
  localparam logic [2:0] CST_C4 = 3'd4;
endpackage

// File: rtl/dcs_res_timer.sv
module dcs_res_timer #(
  parameter int TIMER_W = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               run_i,
  input  logic               clr_i,
  input  logic [TIMER_W-1:0] timeout_i,
  output logic               exp_o
);
  logic [TIMER_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      exp_o <= 1'b0;
    end else if (clr_i) begin
      cnt_q <= '0;
      exp_o <= 1'b0;
    end else if (run_i && !exp_o) begin
      if (cnt_q >= timeout_i) exp_o <= 1'b1;
      else                    cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/dcs_ratio_cmp.sv
module dcs_ratio_cmp #(
  parameter int RATIO_W = 6
) (
  input  logic [RATIO_W-1:0] ratio_i,
  input  logic [RATIO_W-1:0] thr_i,
  output logic               low_o,
  output logic               high_o
);
  logic ignore;
  assign ignore = (ratio_i == '0);
  assign low_o  = ignore || (ratio_i < thr_i);
  assign high_o = !ignore && (ratio_i > thr_i);
endmodule

// File: rtl/dcs_way_mask.sv
module dcs_way_mask #(
  parameter int NUM_WAYS = 8,
  localparam int WAY_W   = $clog2(NUM_WAYS + 1)
) (
  input  logic [WAY_W-1:0]    lo_i,
  input  logic [WAY_W-1:0]    hi_i,
  output logic [NUM_WAYS-1:0] mask_o
);
  // bit i set when lo_i <= i < hi_i
  for (genvar i = 0; i < NUM_WAYS; i++) begin : g_bit
    assign mask_o[i] = (lo_i <= WAY_W'(i)) && (WAY_W'(i) < hi_i);
  end
endmodule

// File: rtl/dcs_way_ctrl.sv
module dcs_way_ctrl
  import dcs_pkg::*;
#(
  parameter int  NUM_WAYS = 8,
  parameter int  RATIO_W  = 6,
  parameter int  TIMER_W  = 16,
  localparam int WAY_W    = $clog2(NUM_WAYS + 1)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [2:0]          core0_cst_i,
  input  logic [2:0]          core1_cst_i,
  input  logic                deep_en_i,
  input  logic                stop_clk_i,
  input  logic                irq_i,
  input  logic                irq_core_i,
  input  logic [RATIO_W-1:0]  ratio_i,
  input  logic [RATIO_W-1:0]  thr_i,
  input  logic [WAY_W-1:0]    step_i,
  input  logic [TIMER_W-1:0]  timeout_i,
  input  logic                hold_full_i,
  input  logic                flush_ack_i,
  output logic [WAY_W-1:0]    ways_en_o,
  output logic [NUM_WAYS-1:0] flush_req_o,
  output logic [NUM_WAYS-1:0] inv_req_o,
  output logic                grow_req_o,
  output logic                deep_ok_o
);
  localparam logic [WAY_W-1:0] FULL_WAYS = WAY_W'(NUM_WAYS);
  localparam logic [WAY_W-1:0] WAKE_WAYS = WAY_W'(2);

  dcs_state_e         st_q;
  logic [WAY_W-1:0]   ways_q, tgt_q, tgt_calc, inv_hi, ways_m1;
  logic               woke_q;
  logic [NUM_WAYS-1:0] inv_q, inv_mask, flush_mask;
  logic               sleep_want, entry, ratio_low, ratio_high, expired;
  logic               shrink_ok, other_light, grow_cond;
  logic [2:0]         other_cst;

  assign sleep_want = (core0_cst_i == CST_C4) && (core1_cst_i == CST_C4) &&
                      deep_en_i && stop_clk_i && !hold_full_i;
  assign entry      = (st_q == ST_RUN) && sleep_want;

  dcs_ratio_cmp #(.RATIO_W(RATIO_W)) u_ratio (
    .ratio_i(ratio_i), .thr_i(thr_i), .low_o(ratio_low), .high_o(ratio_high)
  );

  dcs_res_timer #(.TIMER_W(TIMER_W)) u_timer (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(st_q == ST_RUN), .clr_i(entry),
    .timeout_i(timeout_i), .exp_o(expired)
  );

  assign shrink_ok   = ratio_low && !expired;
  assign tgt_calc    = woke_q ? '0 : ((ways_q > step_i) ? ways_q - step_i : '0);
  assign other_cst   = irq_core_i ? core0_cst_i : core1_cst_i;
  assign other_light = (other_cst >= 3'd1) && (other_cst <= 3'd3);
  assign grow_cond   = ratio_high || expired || other_light;
  assign ways_m1     = ways_q - 1'b1;
  assign inv_hi      = (st_q == ST_SLEEP) ? WAKE_WAYS : FULL_WAYS;

  dcs_way_mask #(.NUM_WAYS(NUM_WAYS)) u_inv_mask (
    .lo_i(ways_q), .hi_i(inv_hi), .mask_o(inv_mask)
  );
  dcs_way_mask #(.NUM_WAYS(NUM_WAYS)) u_flush_mask (
    .lo_i(ways_m1), .hi_i(ways_q), .mask_o(flush_mask)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_RUN;
      ways_q <= FULL_WAYS;
      tgt_q  <= '0;
      woke_q <= 1'b0;
      inv_q  <= '0;
    end else begin
      inv_q <= '0;
      unique case (st_q)
        ST_RUN: begin
          if (hold_full_i || (irq_i && grow_cond)) begin
            if (ways_q != FULL_WAYS) begin
              ways_q <= FULL_WAYS;
              inv_q  <= inv_mask;
              woke_q <= 1'b0;
            end
          end else if (sleep_want) begin
            if (shrink_ok && (tgt_calc < ways_q)) begin
              tgt_q  <= tgt_calc;
              woke_q <= 1'b0;
              st_q   <= ST_FLUSH;
            end else begin
              st_q   <= ST_SLEEP;
            end
          end
        end
        ST_FLUSH: begin
          if (flush_ack_i) begin
            ways_q <= ways_m1;
            if (ways_m1 == tgt_q) st_q <= ST_SLEEP;
          end
        end
        ST_SLEEP: begin
          if (!sleep_want) begin
            st_q <= ST_RUN;
            if (ways_q < WAKE_WAYS) begin
              ways_q <= WAKE_WAYS;
              inv_q  <= inv_mask;
              woke_q <= 1'b1;
            end
          end
        end
        default: st_q <= ST_RUN;
      endcase
    end
  end

  assign ways_en_o   = ways_q;
  assign inv_req_o   = inv_q;
  assign flush_req_o = (st_q == ST_FLUSH) ? flush_mask : '0;
  assign grow_req_o  = ratio_high;
  assign deep_ok_o   = (st_q == ST_SLEEP) && sleep_want;
endmodule

// File: rtl/dcs_way_ctrl_chk.sv
module dcs_way_ctrl_chk #(
  parameter int  NUM_WAYS = 8,
  localparam int WAY_W    = $clog2(NUM_WAYS + 1)
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                hold_full_i,
  input logic                flush_ack_i,
  input logic [WAY_W-1:0]    ways_en_o,
  input logic [NUM_WAYS-1:0] flush_req_o,
  input logic [NUM_WAYS-1:0] inv_req_o,
  input logic                deep_ok_o
);
  assert_flush_onehot_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(flush_req_o));

  assert_ways_bound_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(ways_en_o) <= NUM_WAYS);

  assert_flush_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|flush_req_o && flush_ack_i) |=> int'(ways_en_o) == int'($past(ways_en_o)) - 1);

  assert_no_grant_in_flush_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|flush_req_o) |-> !deep_ok_o);

  assert_hold_no_grant_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_full_i |-> !deep_ok_o);

  assert_inv_range_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|inv_req_o) |-> ($countones(inv_req_o) == int'(ways_en_o) - int'($past(ways_en_o))));
endmodule

bind dcs_way_ctrl dcs_way_ctrl_chk #(.NUM_WAYS(NUM_WAYS)) u_chk (.*);

// File: tb/tb_dcs_way_ctrl.sv
module tb_dcs_way_ctrl;
  localparam int NUM_WAYS = 8;
  localparam int RATIO_W  = 6;
  localparam int TIMER_W  = 16;
  localparam int WAY_W    = $clog2(NUM_WAYS + 1);

  logic clk = 1'b0, rst_n = 1'b0;
  logic [2:0] c0 = '0, c1 = '0;
  logic deep_en = 1'b0, stop_clk = 1'b0, irq = 1'b0, irq_core = 1'b0;
  logic hold = 1'b0, ack = 1'b0;
  logic [RATIO_W-1:0] ratio = '0, thr = 6'd10;
  logic [WAY_W-1:0] step = '0;
  logic [TIMER_W-1:0] timeout = 16'd60000;
  logic [WAY_W-1:0] ways;
  logic [NUM_WAYS-1:0] flush_req, inv_req;
  logic grow_req, deep_ok;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  dcs_way_ctrl #(.NUM_WAYS(NUM_WAYS), .RATIO_W(RATIO_W), .TIMER_W(TIMER_W)) dut (
    .clk_i(clk), .rst_ni(rst_n), .core0_cst_i(c0), .core1_cst_i(c1),
    .deep_en_i(deep_en), .stop_clk_i(stop_clk), .irq_i(irq), .irq_core_i(irq_core),
    .ratio_i(ratio), .thr_i(thr), .step_i(step), .timeout_i(timeout),
    .hold_full_i(hold), .flush_ack_i(ack), .ways_en_o(ways), .flush_req_o(flush_req),
    .inv_req_o(inv_req), .grow_req_o(grow_req), .deep_ok_o(deep_ok)
  );

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic tick(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_entry(logic on);
    c0 = on ? 3'd4 : 3'd0;
    c1 = on ? 3'd4 : 3'd0;
    deep_en = 1'b1;
    stop_clk = on;
  endtask

  // expects flushes of ways hi down to lo, then a grant
  task automatic run_flush(string tag, int hi, int lo);
    tick();
    for (int w = hi; w >= lo; w--) begin
      chk({tag, " flush bit"}, int'(flush_req), 1 << w);
      chk({tag, " R3 no grant while flushing"}, int'(deep_ok), 0);
      ack = 1'b1;
      tick();
      ack = 1'b0;
    end
    chk({tag, " flush done"}, int'(flush_req), 0);
    chk({tag, " R3 grant after last ack"}, int'(deep_ok), 1);
    chk({tag, " ways after shrink"}, int'(ways), lo);
  endtask

  task automatic wake(string tag, int exp_ways, int exp_inv);
    stop_clk = 1'b0;
    tick();
    chk({tag, " R6 ways on wake"}, int'(ways), exp_ways);
    chk({tag, " R6 inv mask"}, int'(inv_req), exp_inv);
    chk({tag, " R6 grant dropped"}, int'(deep_ok), 0);
    tick();
    chk({tag, " R6 inv pulse ends"}, int'(inv_req), 0);
    c0 = 3'd0;
    c1 = 3'd0;
  endtask

  task automatic pulse_irq(logic core);
    irq_core = core;
    irq = 1'b1;
    tick();
    irq = 1'b0;
  endtask

  task automatic direct_grant(string tag);
    set_entry(1'b1);
    tick();
    chk({tag, " no flush"}, int'(flush_req), 0);
    chk({tag, " direct grant"}, int'(deep_ok), 1);
    chk({tag, " ways kept"}, int'(ways), NUM_WAYS);
  endtask

  task automatic test_reset;
    chk("R1 ways", int'(ways), NUM_WAYS);
    chk("R1 flush", int'(flush_req), 0);
    chk("R1 inv", int'(inv_req), 0);
    chk("R1 grant", int'(deep_ok), 0);
    chk("R1 grow", int'(grow_req), 0);
  endtask

  task automatic test_shrink;
    c0 = 3'd4; c1 = 3'd4; stop_clk = 1'b1; deep_en = 1'b0; step = 4'd7;
    tick(3);
    chk("R2 no entry without enable", int'(deep_ok), 0);
    chk("R2 no flush without enable", int'(flush_req), 0);
    deep_en = 1'b1;
    run_flush("R2 step7", 7, 1);
    wake("R6 from one way", 2, 'b10);
  endtask

  task automatic test_reentry;
    step = 4'd1;
    set_entry(1'b1);
    run_flush("R7 to zero", 1, 0);
    wake("R6 from zero", 2, 'b11);
  endtask

  task automatic test_irq;
    c0 = 3'd2; c1 = 3'd0;
    pulse_irq(1'b0);
    chk("R8 servicing core light: no change", int'(ways), 2);
    chk("R8 no inv", int'(inv_req), 0);
    c1 = 3'd3;
    pulse_irq(1'b0);
    chk("R8 other core light: full", int'(ways), NUM_WAYS);
    chk("R8 inv re-enabled", int'(inv_req), 'hFC);
    c0 = 3'd0; c1 = 3'd0;
    tick();
  endtask

  task automatic test_sat;
    step = 4'd0;
    direct_grant("R10 step0");
    wake("R10 step0 wake", NUM_WAYS, 0);
    step = 4'd12;
    set_entry(1'b1);
    run_flush("R10 step12", 7, 0);
    wake("R10 wake", 2, 'b11);
  endtask

  task automatic test_ratio;
    ratio = 6'd12; thr = 6'd10;
    tick();
    chk("R4 grow when high", int'(grow_req), 1);
    pulse_irq(1'b0);
    chk("R8 ratio high: full", int'(ways), NUM_WAYS);
    step = 4'd3;
    direct_grant("R4 high");
    wake("R4 high wake", NUM_WAYS, 0);
    ratio = 6'd10;
    tick();
    chk("R4 equal no grow", int'(grow_req), 0);
    direct_grant("R4 equal");
    wake("R4 equal wake", NUM_WAYS, 0);
    ratio = 6'd0; thr = 6'd0;
    tick();
    chk("R4 zero no grow", int'(grow_req), 0);
    set_entry(1'b1);
    run_flush("R4 zero ignored", 7, 5);
    wake("R4 zero wake", 5, 0);
  endtask

  task automatic test_hold;
    hold = 1'b1;
    set_entry(1'b1);
    tick();
    chk("R9 full", int'(ways), NUM_WAYS);
    chk("R9 inv", int'(inv_req), 'hE0);
    for (int i = 0; i < 5; i++) begin
      chk("R9 no grant", int'(deep_ok), 0);
      chk("R9 no flush", int'(flush_req), 0);
      tick();
    end
    stop_clk = 1'b0;
    tick();
    hold = 1'b0;
    c0 = 3'd0; c1 = 3'd0;
    tick();
  endtask

  task automatic test_timer;
    step = 4'd3;
    set_entry(1'b1);
    run_flush("R5 prep", 7, 5);
    wake("R5 prep wake", 5, 0);
    timeout = 16'd20;
    tick(30);
    pulse_irq(1'b1);
    chk("R8 timer expired: full", int'(ways), NUM_WAYS);
    chk("R8 timer inv", int'(inv_req), 'hE0);
    tick();
    direct_grant("R5 expired");
    wake("R5 expired wake", NUM_WAYS, 0);
    set_entry(1'b1);
    run_flush("R5 cleared by entry", 7, 5);
    wake("R5 final wake", 5, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick();
    test_reset();
    test_shrink();
    test_reentry();
    test_irq();
    test_sat();
    test_ratio();
    test_hold();
    test_timer();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule